// File: doc/BRIEF.md
# Change-of-State Interrupt Controller

This block watches a 32-bit word of already-synchronised digital inputs, arranged as four byte-wide groups. Groups 0 to 2 carry isolated field inputs and group 3 carries the TTL byte. For each input bit it keeps a sticky change-of-state flag. The flag is set when that bit shows an edge whose direction is enabled for its group.

An 8-bit enable register selects the edge direction per group. Its low nibble holds the rising-edge enables and its high nibble the falling-edge enables. Software reads all 32 flags at once and clears them with a write-one-to-clear word gated by per-byte enables. Software normally writes back exactly the flags it has read, so flags that arrive in between stay pending.

A two-state interrupt machine drives one level interrupt and a readable interrupt status byte:
- `IRQ_QUIET`: no flag is latched.
- `IRQ_PENDING`: at least one flag is latched.
- Transition `RAISE` (QUIET to PENDING): taken when the next flag word is non-zero.
- Transition `DROP` (PENDING to QUIET): taken when the next flag word is all zero.

A soft-reset pulse empties the flag word.

Top module: `cosi_ctrl`

## Requirements
- R1: Flag bit 8*g+i belongs to input bit 8*g+i, which is bit i of group g. Group 3 is the TTL byte (bits 24-31).
- R2: A flag is set only by an edge whose direction is enabled for its group. Enable bit g (0-3) enables rising edges of group g, and enable bit 4+g enables falling edges of group g. With both bits set, either edge sets the flag.
- R3: Edges are found by comparing each input with its value one clock earlier. The flag reads 1 at the first clock edge after the input change.
- R4: The enable register resets to 0x00 and reads back the value last written.
- R5: No flag is set on leaving reset, whatever the input values were during reset.
- R6: Writing a 1 to a flag bit whose byte enable is set clears that flag. Bits written 0, and bits in bytes whose enable is low, keep their value.
- R7: `irq` is high in exactly the cycles in which at least one flag is set. It stays high until all 32 flags are clear.
- R8: `irq_stat` bit 0 equals `irq`, and bits 7:1 read 0.
- R9: `soft_rst` clears every flag at the next clock edge and takes priority over edges in the same cycle. The enable register keeps its value.
- R10: If a qualifying edge on a bit coincides with a clear of that bit, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sense_in | input | 32 | Synchronised inputs, four byte groups |
| edge_en_wr | input | 1 | Write strobe for the enable register |
| edge_en_wdata | input | 8 | Enable value: [3:0] rising per group, [7:4] falling per group |
| edge_en_rdata | output | 8 | Enable register read-back |
| flag_rdata | output | 32 | Latched change-of-state flags |
| clr_wr | input | 1 | Write strobe for the clear word |
| clr_be | input | 4 | Byte enables for the clear word |
| clr_wdata | input | 32 | Write-one-to-clear data |
| soft_rst | input | 1 | One-cycle soft reset of the flags |
| irq | output | 1 | Level interrupt |
| irq_stat | output | 8 | Interrupt status byte (bit 0 = irq) |

## Verification
On every cycle the assertions check four things:
- the interrupt level agrees with the flag word;
- no flag appears while all edge enables are off;
- a clear write of zeros drops no flag;
- the soft reset empties the flags and enable writes read back.

Only the bench's scenarios can show the rest, namely the direction and group mapping of edges, byte-enable masking of clears, the survival of a flag when an edge collides with its clear, and that no flag appears on leaving reset with non-zero inputs.

// File: rtl/cosi_pkg.sv
package cosi_pkg;
    localparam int COSI_GROUP_W    = 8;
    localparam int COSI_NUM_GROUPS = 4;

    typedef enum logic {
        IRQ_QUIET   = 1'b0,
        IRQ_PENDING = 1'b1
    } cosi_irq_state_e;
endpackage

// File: rtl/cosi_edge_det.sv
module cosi_edge_det #(
    parameter int GROUP_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [GROUP_W-1:0] grp_in,
    input  logic               rise_en,
    input  logic               fall_en,
    output logic [GROUP_W-1:0] hit
);
    logic [GROUP_W-1:0] prev_q;

    // During reset the delayed copy tracks the input, so that leaving reset shows no edge.
    always_ff @(posedge clk) begin
        prev_q <= grp_in;
    end

    always_comb begin
        hit = ({GROUP_W{rise_en}} & grp_in & ~prev_q)
            | ({GROUP_W{fall_en}} & ~grp_in & prev_q);
        if (!rst_n) hit = '0;
    end
endmodule

// File: rtl/cosi_flag_bank.sv
module cosi_flag_bank #(
    parameter int GROUP_W    = 8,
    parameter int NUM_GROUPS = 4,
    localparam int DW        = GROUP_W * NUM_GROUPS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  soft_rst,
    input  logic [DW-1:0]         hit,
    input  logic                  clr_wr,
    input  logic [NUM_GROUPS-1:0] clr_be,
    input  logic [DW-1:0]         clr_wdata,
    output logic [DW-1:0]         flags,
    output logic                  any_nxt
);
    logic [DW-1:0] clr_mask;
    logic [DW-1:0] flags_nxt;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_mask
        assign clr_mask[g*GROUP_W +: GROUP_W] =
            {GROUP_W{clr_wr & clr_be[g]}} & clr_wdata[g*GROUP_W +: GROUP_W];
    end

    // A new hit is ORed in after the clear, so a colliding event survives (R10).
    always_comb begin
        flags_nxt = (flags & ~clr_mask) | hit;
        if (soft_rst) flags_nxt = '0;
    end

    assign any_nxt = |flags_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= flags_nxt;
    end
endmodule

// File: rtl/cosi_irq_fsm.sv
module cosi_irq_fsm
    import cosi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_nxt,
    output logic irq
);
    cosi_irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:   if (any_nxt)  state_d = IRQ_PENDING; // RAISE
            IRQ_PENDING: if (!any_nxt) state_d = IRQ_QUIET;   // DROP
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == IRQ_PENDING);
    end
endmodule

// File: rtl/cosi_ctrl.sv
module cosi_ctrl
    import cosi_pkg::*;
#(
    parameter int GROUP_W    = COSI_GROUP_W,
    parameter int NUM_GROUPS = COSI_NUM_GROUPS,
    localparam int DW        = GROUP_W * NUM_GROUPS,
    localparam int EW        = 2 * NUM_GROUPS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DW-1:0]         sense_in,
    input  logic                  edge_en_wr,
    input  logic [EW-1:0]         edge_en_wdata,
    output logic [EW-1:0]         edge_en_rdata,
    output logic [DW-1:0]         flag_rdata,
    input  logic                  clr_wr,
    input  logic [NUM_GROUPS-1:0] clr_be,
    input  logic [DW-1:0]         clr_wdata,
    input  logic                  soft_rst,
    output logic                  irq,
    output logic [7:0]            irq_stat
);
    logic [EW-1:0] en_q;
    logic [DW-1:0] hit;
    logic          any_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n)          en_q <= '0;
        else if (edge_en_wr) en_q <= edge_en_wdata;
    end
    assign edge_en_rdata = en_q;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        cosi_edge_det #(.GROUP_W(GROUP_W)) u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .grp_in  (sense_in[g*GROUP_W +: GROUP_W]),
            .rise_en (en_q[g]),
            .fall_en (en_q[NUM_GROUPS+g]),
            .hit     (hit[g*GROUP_W +: GROUP_W])
        );
    end

    cosi_flag_bank #(.GROUP_W(GROUP_W), .NUM_GROUPS(NUM_GROUPS)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .hit       (hit),
        .clr_wr    (clr_wr),
        .clr_be    (clr_be),
        .clr_wdata (clr_wdata),
        .flags     (flag_rdata),
        .any_nxt   (any_nxt)
    );

    cosi_irq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_nxt (any_nxt),
        .irq     (irq)
    );

    assign irq_stat = {7'b0, irq};
endmodule

// File: rtl/cosi_ctrl_chk.sv
module cosi_ctrl_chk #(
    parameter int GROUP_W    = 8,
    parameter int NUM_GROUPS = 4,
    localparam int DW        = GROUP_W * NUM_GROUPS,
    localparam int EW        = 2 * NUM_GROUPS
) (
    input logic          clk,
    input logic          rst_n,
    input logic          soft_rst,
    input logic          clr_wr,
    input logic [DW-1:0] clr_wdata,
    input logic          edge_en_wr,
    input logic [EW-1:0] edge_en_wdata,
    input logic [EW-1:0] edge_en_rdata,
    input logic [DW-1:0] flag_rdata,
    input logic          irq
);
    p_irq_tracks_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|flag_rdata));

    p_no_flag_when_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_en_rdata == '0) |=> ((flag_rdata & ~$past(flag_rdata)) == '0));

    p_zero_clear_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_wdata == '0 && !soft_rst) |=>
            ((flag_rdata & $past(flag_rdata)) == $past(flag_rdata)));

    p_soft_reset_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (flag_rdata == '0));

    p_enable_readback_r4: assert property (@(posedge clk) disable iff (!rst_n)
        edge_en_wr |=> (edge_en_rdata == $past(edge_en_wdata)));
endmodule

bind cosi_ctrl cosi_ctrl_chk #(.GROUP_W(GROUP_W), .NUM_GROUPS(NUM_GROUPS)) u_chk (.*);

// File: tb/cosi_ctrl_bench.sv
`timescale 1ns/1ps
module cosi_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] sense_in;
    logic        edge_en_wr;
    logic [7:0]  edge_en_wdata;
    logic [7:0]  edge_en_rdata;
    logic [31:0] flag_rdata;
    logic        clr_wr;
    logic [3:0]  clr_be;
    logic [31:0] clr_wdata;
    logic        soft_rst;
    logic        irq;
    logic [7:0]  irq_stat;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    cosi_ctrl u_cosi_ctrl (.*);

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_en(input logic [7:0] v);
        edge_en_wr = 1'b1; edge_en_wdata = v;
        step();
        edge_en_wr = 1'b0;
    endtask

    task automatic clear(input logic [3:0] be, input logic [31:0] d);
        clr_wr = 1'b1; clr_be = be; clr_wdata = d;
        step();
        clr_wr = 1'b0; clr_be = '0; clr_wdata = '0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; sense_in = 32'hA5C3_0FF0;
        edge_en_wr = 0; edge_en_wdata = 0; clr_wr = 0; clr_be = 0; clr_wdata = 0; soft_rst = 0;
        repeat (3) step();
        rst_n = 1'b1;
        step(); step();
        chk("R4 enable reset", {24'b0, edge_en_rdata}, 32'h0);
        chk("R5 no flags after reset", flag_rdata, 32'h0);
        chk("R7 irq after reset", {31'b0, irq}, 32'h0);
        chk("R8 irq_stat after reset", {24'b0, irq_stat}, 32'h0);
        set_en(8'hFF);
        step();
        chk("R5 no spurious flag once enabled", flag_rdata, 32'h0);
        chk("R4 enable readback", {24'b0, edge_en_rdata}, 32'hFF);
        set_en(8'h00);
        sense_in = 32'h0; step();
    endtask

    task automatic t_rising();
        set_en(8'h01);
        sense_in = 32'h0000_0008;
        step();
        chk("R3 rising flag one clock later", flag_rdata, 32'h0000_0008);
        chk("R7 irq raised", {31'b0, irq}, 32'h1);
        chk("R8 irq_stat active", {24'b0, irq_stat}, 32'h1);
        clear(4'h1, 32'h0000_0008);
        sense_in = 32'h0; step(); step();
        chk("R2 falling ignored when only rising enabled", flag_rdata, 32'h0);
        chk("R7 irq quiet", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_group_map();
        set_en(8'h0F);
        sense_in = 32'h0400_0000; step();
        chk("R1 TTL bit 26 maps to flag 26", flag_rdata, 32'h0400_0000);
        clear(4'hF, 32'hFFFF_FFFF);
        sense_in = 32'h0400_0000 | 32'h0001_0200; step();
        chk("R1 bits 9 and 16 groups 1,2", flag_rdata, 32'h0001_0200);
        clear(4'hF, 32'hFFFF_FFFF);
        sense_in = 32'h0; step(); step();
        chk("R2 falls ignored with rising only", flag_rdata, 32'h0);
    endtask

    task automatic t_falling();
        set_en(8'h80);
        sense_in = 32'h4000_0001; step(); step();
        chk("R2 rise ignored with falling only", flag_rdata, 32'h0);
        sense_in = 32'h0; step();
        chk("R2 TTL falling edge sets bit 30 only", flag_rdata, 32'h4000_0000);
        clear(4'h8, 32'h4000_0000);
        chk("R6 cleared", flag_rdata, 32'h0);
    endtask

    task automatic t_both();
        set_en(8'h22);
        sense_in = 32'h0000_0200; step();
        chk("R2 both enabled, rising", flag_rdata, 32'h0000_0200);
        clear(4'h2, 32'h0000_0200);
        sense_in = 32'h0; step();
        chk("R2 both enabled, falling", flag_rdata, 32'h0000_0200);
        clear(4'h2, 32'h0000_0200);
    endtask

    task automatic t_clear_be();
        set_en(8'h0F);
        sense_in = 32'h0011_0011; step();
        chk("R6 setup two bytes", flag_rdata, 32'h0011_0011);
        clear(4'h1, 32'hFFFF_FFFF);
        chk("R6 byte enable limits clear", flag_rdata, 32'h0011_0000);
        chk("R7 irq held while flags remain", {31'b0, irq}, 32'h1);
        clear(4'h4, 32'h0001_0000);
        chk("R6 zero bits kept", flag_rdata, 32'h0010_0000);
        clear(4'h4, 32'h0010_0000);
        chk("R7 irq drops when all clear", {31'b0, irq}, 32'h0);
        sense_in = 32'h0; step();
    endtask

    task automatic t_collision();
        set_en(8'h01);
        sense_in = 32'h20; step();
        sense_in = 32'h0; step();
        chk("R10 setup", flag_rdata, 32'h20);
        sense_in = 32'h20;
        clr_wr = 1'b1; clr_be = 4'h1; clr_wdata = 32'h20;
        step();
        clr_wr = 1'b0; clr_be = 0; clr_wdata = 0;
        chk("R10 edge during clear survives", flag_rdata, 32'h20);
        clear(4'h1, 32'h20);
        chk("R10 later clear works", flag_rdata, 32'h0);
        sense_in = 32'h0; step();
    endtask

    task automatic t_soft();
        set_en(8'h0F);
        sense_in = 32'h8000_0001; step();
        chk("R9 setup", flag_rdata, 32'h8000_0001);
        sense_in = 32'h8000_0003; soft_rst = 1'b1;
        step();
        soft_rst = 1'b0;
        chk("R9 soft reset clears and beats edge", flag_rdata, 32'h0);
        chk("R9 irq low after soft reset", {31'b0, irq}, 32'h0);
        chk("R9 enable kept", {24'b0, edge_en_rdata}, 32'h0F);
    endtask

    initial begin
        t_reset();
        t_rising();
        t_group_map();
        t_falling();
        t_both();
        t_clear_be();
        t_collision();
        t_soft();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule